// File: doc/BRIEF.md
# Battery-Backed Byte SRAM with Supply-Loss Guard

This block is a clocked behavioural model of a 2048-byte static RAM. It has an 11-bit address, an 8-bit tri-state data bus and three active-low controls: chip select, output enable and write strobe. Two digital status inputs take the place of analogue supply sensing. `pwr_ok` is high while the supply is inside tolerance. `batt_low` reports that the backup cell was found weak when power returned. The array keeps its contents across supply loss, much as a battery would hold them.

While the supply is out of tolerance, the block deselects itself. The bus floats and every control, address and data input is ignored. When `pwr_ok` rises, the block samples `batt_low` once. If it is high, a sticky battery-warning flag is set. The next write attempt is then dropped without any sign on the bus, and that attempt clears the flag. Software can find a weak cell by writing the complement of a byte and reading it back. The flag is also brought out on a read-only pin for observation.

All controls are sampled on `clk`. A write is in progress while chip select and write strobe are both low. It takes effect in the first cycle in which that joint condition ends, using the address and data present in that cycle.

Top module: `nvs_guard`

## Requirements
- R1: Each of the 2048 byte locations, selected by `addr[10:0]`, returns the last byte written to it when read with `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R2: `dq` is driven only while `pwr_ok`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1. In every other case `dq` is high impedance.
- R3: With `ce_n`=1 the bus floats and no write starts, whatever `oe_n` and `we_n` are.
- R4: A low `we_n` with `ce_n` low turns the output drivers off, even when `oe_n` is low.
- R5: A write commits in the first clock cycle in which `ce_n`=0 and `we_n`=0 stop holding together. This is true whether `we_n` rises first or `ce_n` rises first.
- R6: The data and address stored are those sampled in the cycle that ends the write. Earlier values presented during the same write are discarded.
- R7: While `pwr_ok`=0 nothing is written. This includes a write that was in progress when `pwr_ok` fell. The bus stays high impedance.
- R8: On each rising edge of `pwr_ok`, `batt_flag` takes the value of `batt_low` in that cycle. It is visible one cycle later.
- R9: While `batt_flag`=1, the next write attempt leaves the array unchanged and clears `batt_flag`. The write after it stores normally.
- R10: `batt_low` has no effect except in the cycle where `pwr_ok` rises.
- R11: Array contents survive any number of `pwr_ok` low periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset for control state |
| addr | input | 11 | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| pwr_ok | input | 1 | Supply inside tolerance |
| batt_low | input | 1 | Backup cell weak, sampled at power return |
| batt_flag | output | 1 | Battery-warning flag, read-only observation |

## Verification
The bench builds the block with its defaults: 11 address bits and 8 data bits. At that size both the lowest and highest addresses (0x000 and 0x7FF) can be written and read back. The bench ends writes in both orders, by raising `we_n` first and by raising `ce_n` first. It also changes data inside a write window, removes power in the middle of a write, and runs power cycles with `batt_low` both high and low. This covers the one-shot write swallow and the survival of contents across supply loss.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;
  localparam int unsigned NVS_ADDR_W = 11;
  localparam int unsigned NVS_DATA_W = 8;

  // Decoded state of the bus control pins for one cycle
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2,
    BUS_OFF   = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/nvs_pwr_mon.sv
`timescale 1ns/1ps
module nvs_pwr_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic batt_low,
  input  logic wr_try,
  output logic pwr_up,
  output logic flag
);
  logic pwr_q;
  logic flag_q, flag_d;
  logic flag_en;

  assign pwr_up = pwr_ok & ~pwr_q;

  // next state: load on power return, clear on the consumed write attempt
  always_comb begin
    flag_en = pwr_up | wr_try;
    flag_d  = flag_q;
    if (pwr_up) begin
      flag_d = batt_low;
    end else if (wr_try) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b0;
    end else begin
      pwr_q <= pwr_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/nvs_bus_ctrl.sv
`timescale 1ns/1ps
module nvs_bus_ctrl
  import nvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic bus_oe,
  output logic wr_try
);
  bus_mode_e mode;
  logic      wr_hold_q, wr_hold_d;

  always_comb begin
    if (!pwr_ok) begin
      mode = BUS_OFF;
    end else if (ce_n) begin
      mode = BUS_IDLE;
    end else if (!we_n) begin
      mode = BUS_WRITE;
    end else begin
      mode = BUS_READ;
    end
  end

  // A write is in progress while the joint enable holds under good power
  always_comb begin
    wr_hold_d = (mode == BUS_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold_q <= 1'b0;
    end else begin
      wr_hold_q <= wr_hold_d;
    end
  end

  // End of write: joint enable dropped this cycle while power stayed good
  assign wr_try = wr_hold_q & pwr_ok & (mode != BUS_WRITE);
  assign bus_oe = (mode == BUS_READ) & ~oe_n;
endmodule

// File: rtl/nvs_array.sv
`timescale 1ns/1ps
module nvs_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // storage models retained contents: no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      cells[addr] <= wr_data;
    end
  end

  assign rd_data = cells[addr];
endmodule

// File: rtl/nvs_guard.sv
`timescale 1ns/1ps
module nvs_guard
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = NVS_ADDR_W,
  parameter int unsigned DATA_W = NVS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pwr_ok,
  input  logic              batt_low,
  output logic              batt_flag
);
  logic              bus_oe;
  logic              wr_try;
  logic              pwr_up;
  logic              flag;
  logic              mem_we;
  logic [DATA_W-1:0] rd_data;

  nvs_bus_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .bus_oe (bus_oe),
    .wr_try (wr_try)
  );

  nvs_pwr_mon u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_ok   (pwr_ok),
    .batt_low (batt_low),
    .wr_try   (wr_try),
    .pwr_up   (pwr_up),
    .flag     (flag)
  );

  // the attempt that clears a raised flag is itself swallowed
  assign mem_we = wr_try & ~flag;

  nvs_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .addr    (addr),
    .wr_data (dq),
    .rd_data (rd_data)
  );

  assign dq        = bus_oe ? rd_data : {DATA_W{1'bz}};
  assign batt_flag = flag;

  logic unused_pwr_up;
  assign unused_pwr_up = pwr_up;
endmodule

// File: rtl/nvs_guard_chk.sv
`timescale 1ns/1ps
module nvs_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic pwr_ok,
  input logic batt_low,
  input logic flag,
  input logic bus_oe
);
  // R2 / R3 / R7: drivers stay off unless selected, enabled and powered
  a_r2_drive_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !pwr_ok) |-> !bus_oe);

  // R4: write strobe low keeps the drivers off
  a_r4_write_disables_out: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !bus_oe);

  // R8: flag follows battery status captured at power return
  a_r8_flag_on_power_return: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |=> (flag == $past(batt_low)));

  // R9: a write ending while the flag is raised clears it
  a_r9_attempt_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && pwr_ok && $past(pwr_ok) && $past(!ce_n && !we_n) && (ce_n || we_n)) |=> !flag);

  // R10: with power steady for two cycles the flag cannot newly rise
  a_r10_no_rise_while_powered: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && pwr_ok && $past(pwr_ok) && $past(pwr_ok, 2)) |-> !$rose(flag));

  // R7: unpowered cycles never alter the flag
  a_r7_flag_frozen_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable(flag));
endmodule

bind nvs_guard nvs_guard_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .we_n     (we_n),
  .pwr_ok   (pwr_ok),
  .batt_low (batt_low),
  .flag     (batt_flag),
  .bus_oe   (bus_oe)
);

// File: tb/tb_nvs_guard.sv
`timescale 1ns/1ps
module tb_nvs_guard;
  localparam real TCK = 8.0;

  logic        clk;
  logic        rst_n;
  logic [10:0] addr;
  wire  [7:0]  dq;
  logic        ce_n, oe_n, we_n;
  logic        pwr_ok, batt_low;
  logic        batt_flag;
  logic        drv_en;
  logic [7:0]  drv_val;

  int n_checks = 0;
  int n_fails  = 0;

  assign dq = drv_en ? drv_val : 8'hzz;

  nvs_guard dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq(dq),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .pwr_ok(pwr_ok), .batt_low(batt_low), .batt_flag(batt_flag)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  typedef struct {
    bit         is_flag;
    bit         want_z;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  // driver side: push expectations
  task automatic expect_bus(input logic [7:0] e, input bit z, input string tag);
    item_t it;
    it.is_flag = 1'b0; it.want_z = z; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic expect_flag(input bit e, input string tag);
    item_t it;
    it.is_flag = 1'b1; it.want_z = 1'b0; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compares mid-cycle, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_checks++;
        if (it.is_flag) begin
          if (batt_flag !== it.exp[0]) begin
            n_fails++;
            $display("FAIL %s: batt_flag=%b expected %b", it.tag, batt_flag, it.exp[0]);
          end
        end else if (it.want_z) begin
          if (dq !== 8'hzz) begin
            n_fails++;
            $display("FAIL %s: dq=%h expected zz", it.tag, dq);
          end
        end else if (dq !== it.exp) begin
          n_fails++;
          $display("FAIL %s: dq=%h expected %h", it.tag, dq, it.exp);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; drv_en = 1'b0;
  endtask

  // write ended by we_n rising first
  task automatic wr_we(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; drv_val = d; drv_en = 1'b1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; drv_en = 1'b0;
  endtask

  // write ended by ce_n rising first
  task automatic wr_ce(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; drv_val = d; drv_en = 1'b1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1; drv_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a; drv_en = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 expect_bus(e, 1'b0, tag);
  endtask

  task automatic power(input bit on, input bit low);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; drv_en = 1'b0;
    batt_low = low; pwr_ok = on;
  endtask

  initial begin
    #(TCK*200000);
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    pwr_ok = 1'b0; batt_low = 1'b0; drv_en = 1'b0; drv_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: flag clear, bus floating (R3)
    @(negedge clk);
    #1 expect_flag(1'b0, "R8 reset flag");
    expect_bus(8'h00, 1'b1, "R3 reset bus");

    // power-up with a good cell: flag stays clear (R8)
    power(1'b1, 1'b0);
    @(negedge clk);
    #1 expect_flag(1'b0, "R8 good cell");

    // basic writes in both orders, range ends (R1, R5)
    wr_we(11'h100, 8'hA5);
    rd(11'h100, 8'hA5, "R5 we-ended write");
    wr_ce(11'h7FF, 8'h3C);
    rd(11'h7FF, 8'h3C, "R5 ce-ended write top address");
    wr_we(11'h000, 8'h81);
    rd(11'h000, 8'h81, "R1 bottom address");
    rd(11'h7FF, 8'h3C, "R1 neighbour intact");

    // data changed inside the window: last value wins (R6)
    @(negedge clk);
    addr = 11'h055; drv_val = 8'h11; drv_en = 1'b1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    drv_val = 8'h22;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; drv_en = 1'b0;
    rd(11'h055, 8'h22, "R6 ending-cycle data");

    // output gating (R2, R3, R4)
    @(negedge clk);
    addr = 11'h100; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    #1 expect_bus(8'h00, 1'b1, "R2 oe high floats");
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    #1 expect_bus(8'h00, 1'b1, "R3 ce high floats");
    @(negedge clk);
    addr = 11'h3FF; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1 expect_bus(8'h00, 1'b1, "R4 strobe low floats");
    idle();

    // supply out of tolerance: no drive, no writes (R7)
    power(1'b0, 1'b0);
    @(negedge clk);
    addr = 11'h100; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 expect_bus(8'h00, 1'b1, "R7 read while unpowered");
    idle();
    wr_we(11'h100, 8'hFF);
    power(1'b1, 1'b0);
    rd(11'h100, 8'hA5, "R7 write while unpowered ignored");

    // power lost during a write (R7)
    @(negedge clk);
    addr = 11'h000; drv_val = 8'h99; drv_en = 1'b1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; drv_en = 1'b0;
    power(1'b1, 1'b0);
    rd(11'h000, 8'h81, "R7 interrupted write dropped");

    // weak cell at power return (R8, R9)
    power(1'b0, 1'b1);
    power(1'b1, 1'b1);
    @(negedge clk);
    batt_low = 1'b0;
    #1 expect_flag(1'b1, "R8 weak cell sets flag");
    wr_we(11'h100, 8'h5A);
    @(negedge clk);
    #1 expect_flag(1'b0, "R9 attempt clears flag");
    rd(11'h100, 8'hA5, "R9 first write swallowed");
    wr_ce(11'h100, 8'h5A);
    rd(11'h100, 8'h5A, "R9 second write stores");

    // batt_low while powered has no effect (R10)
    power(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    #1 expect_flag(1'b0, "R10 batt_low ignored while powered");
    batt_low = 1'b0;
    wr_we(11'h200, 8'h66);
    rd(11'h200, 8'h66, "R10 write not swallowed");

    // power cycle with good cell, then retention (R8, R11)
    power(1'b0, 1'b0);
    repeat (5) @(negedge clk);
    power(1'b1, 1'b0);
    @(negedge clk);
    #1 expect_flag(1'b0, "R8 good cell after cycle");
    rd(11'h7FF, 8'h3C, "R11 top byte retained");
    rd(11'h055, 8'h22, "R11 byte retained");
    rd(11'h100, 8'h5A, "R11 rewritten byte retained");

    idle();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule